// File: doc/BRIEF.md
# Programmable duty-cycle serial clock generator

This block derives a serial clock for a serial peripheral shifter from the system clock. The system clock first passes through a power-of-two prescaler. Two 8-bit counts then set how many prescaled ticks the serial clock spends low and how many it spends high, so the duty cycle is set independently of the period. While stopped, the serial clock rests at the level chosen by the polarity input.

Each transition of the serial clock comes with a one-cycle strobe. A leading strobe marks the move away from the idle level and a trailing strobe marks the return to it, so a shifter can sample and launch data without edge detection of its own. When the serial function is off, the same prescaler serves a 16-bit reload timer. The high count forms the upper byte of the reload value and the low count forms the lower byte. The timer emits a one-cycle tick each time its count wraps.

Top module: `spi_clk_gen`

## Requirements
- R1: The prescaler emits one enable every 2^scale_i system clocks, so every phase and timer length is scaled by 2^scale_i (scale_i from 0 to 15).
- R2: While running, sclk_o stays low for low_i × 2^scale_i system clocks per period, measured between consecutive strobes.
- R3: While running, sclk_o stays high for high_i × 2^scale_i system clocks per period, measured between consecutive strobes.
- R4: If low_i or high_i is 0, no serial clock is generated: sclk_o holds the idle level and no strobe occurs, even with run_en_i at 1.
- R5: The idle level of sclk_o equals cpol_i. With cpol_i = 0 the first transition goes high; with cpol_i = 1 it goes low.
- R6: lead_o is high for exactly one cycle, in the cycle sclk_o first shows the non-idle level (sclk_o = !cpol_i). trail_o is high for one cycle in the cycle sclk_o returns to cpol_i. The two are never high together.
- R7: One clock after run_en_i falls, sclk_o equals cpol_i and no further strobe occurs.
- R8: With timer_mode_i = 1 and run_en_i = 0, the reload value is {high_i, low_i} (high_i in bits 15:8). tick_o pulses for one cycle every (reload + 1) × 2^scale_i system clocks, including reload = 0.
- R9: timer_mode_i has no effect while run_en_i = 1: tick_o stays 0.
- R10: After reset, sclk_o, lead_o, trail_o and tick_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_en_i | input | 1 | Serial clock generation enable |
| cpol_i | input | 1 | Idle level of sclk_o |
| scale_i | input | 4 | Prescaler exponent, divide by 2^scale_i |
| low_i | input | 8 | Low phase length in prescaled ticks; reload bits 7:0 in timer mode |
| high_i | input | 8 | High phase length in prescaled ticks; reload bits 15:8 in timer mode |
| timer_mode_i | input | 1 | Selects reload timer operation while run_en_i is 0 |
| sclk_o | output | 1 | Serial clock |
| lead_o | output | 1 | One-cycle strobe on the transition away from idle |
| trail_o | output | 1 | One-cycle strobe on the transition back to idle |
| tick_o | output | 1 | One-cycle timer wrap pulse |

## Verification
The assertions check on every cycle that the two strobes are exclusive, that sclk_o never changes while running without a strobe, that a leading strobe always shows the non-idle level, that stopping silences the strobes, and that no tick appears while the serial function runs. Exact phase lengths, the prescaler scaling, the byte order of the timer reload and the idle behaviour under zero counts depend on configured values over many cycles. Only the bench's scenarios can show these: its scoreboard predicts the sequence of strobe and tick gaps for each configuration and compares each one as it occurs.

// File: rtl/spi_clk_pkg.sv
package spi_clk_pkg;
  parameter int SCALE_W = 4;
  parameter int CNT_W   = 8;

  typedef struct packed {
    logic [CNT_W-1:0] high;
    logic [CNT_W-1:0] low;
  } phase_cfg_t;
endpackage

// File: rtl/spi_clk_prescale.sv
module spi_clk_prescale #(
  parameter int SCALE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic               tick_en_o
);
  localparam int PRE_W = (2 ** SCALE_W) - 1;

  logic [PRE_W:0]   span, span_m1;
  logic [PRE_W-1:0] mask, cnt_q;

  always_comb begin
    span    = {{PRE_W{1'b0}}, 1'b1} << scale_i;
    span_m1 = span - 1'b1;
    mask    = span_m1[PRE_W-1:0];
  end

  assign tick_en_o = run_i && (cnt_q == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!run_i)    cnt_q <= '0;
    else if (tick_en_o) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  // R1: with a nonzero scale, enables never land on adjacent cycles
  p_pre_spaced_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_en_o && scale_i != '0 && run_i) |=> (!tick_en_o || !$stable(scale_i)));
endmodule

// File: rtl/spi_clk_phase.sv
module spi_clk_phase
  import spi_clk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  input  logic       tick_en_i,
  input  logic       cpol_i,
  input  phase_cfg_t cfg_i,
  output logic       sclk_o,
  output logic       lead_o,
  output logic       trail_o
);
  logic             sclk_q, lead_q, trail_q;
  logic [CNT_W-1:0] cnt_q, cur_len;
  logic             hit;

  assign cur_len = sclk_q ? cfg_i.high : cfg_i.low;
  assign hit     = active_i && tick_en_i && (cnt_q == cur_len - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      cnt_q   <= '0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else if (!active_i) begin
      sclk_q  <= cpol_i;
      cnt_q   <= '0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      lead_q  <= hit && (sclk_q == cpol_i);
      trail_q <= hit && (sclk_q != cpol_i);
      if (hit) begin
        sclk_q <= ~sclk_q;
        cnt_q  <= '0;
      end else if (tick_en_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sclk_o  = sclk_q;
  assign lead_o  = lead_q;
  assign trail_o = trail_q;

  p_strobe_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lead_q, trail_q}));

  p_edge_has_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(active_i) && active_i && sclk_q != $past(sclk_q)) |-> (lead_q || trail_q));

  p_lead_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lead_q && $stable(cpol_i)) |-> (sclk_q != cpol_i));

  p_stop_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (!lead_q && !trail_q));
endmodule

// File: rtl/spi_clk_timer.sv
module spi_clk_timer
  import spi_clk_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         active_i,
  input  logic         tick_en_i,
  input  phase_cfg_t   cfg_i,
  output logic         tick_o
);
  localparam int TMR_W = 2 * CNT_W;

  logic [TMR_W-1:0] reload, cnt_q;
  logic             tick_q;

  assign reload = {cfg_i.high, cfg_i.low};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (!active_i) begin
      cnt_q  <= reload;
      tick_q <= 1'b0;
    end else if (tick_en_i) begin
      tick_q <= (cnt_q == '0);
      cnt_q  <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
    end else begin
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

  p_tick_needs_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |-> $past(active_i));
endmodule

// File: rtl/spi_clk_gen.sv
module spi_clk_gen
  import spi_clk_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_en_i,
  input  logic               cpol_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [CNT_W-1:0]   low_i,
  input  logic [CNT_W-1:0]   high_i,
  input  logic               timer_mode_i,
  output logic               sclk_o,
  output logic               lead_o,
  output logic               trail_o,
  output logic               tick_o
);
  phase_cfg_t cfg;
  logic       spi_act, tmr_act, tick_en;

  assign cfg.low  = low_i;
  assign cfg.high = high_i;
  assign spi_act  = run_en_i && (low_i != '0) && (high_i != '0);
  assign tmr_act  = timer_mode_i && !run_en_i;

  spi_clk_prescale #(.SCALE_W(SCALE_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (spi_act || tmr_act),
    .scale_i   (scale_i),
    .tick_en_o (tick_en)
  );

  spi_clk_phase u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (spi_act),
    .tick_en_i (tick_en),
    .cpol_i    (cpol_i),
    .cfg_i     (cfg),
    .sclk_o    (sclk_o),
    .lead_o    (lead_o),
    .trail_o   (trail_o)
  );

  spi_clk_timer u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (tmr_act),
    .tick_en_i (tick_en),
    .cfg_i     (cfg),
    .tick_o    (tick_o)
  );

  p_no_tick_when_run_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_en_i |=> !tick_o);

  p_zero_count_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_i == '0 || high_i == '0) |=> (!lead_o && !trail_o));
endmodule

// File: tb/spi_clk_gen_bench.sv
`timescale 1ns/1ps
module spi_clk_gen_bench;
  localparam int K_LEAD = 0, K_TRAIL = 1, K_TICK = 2;

  typedef struct { int kind; int gap; string req; } item_t;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       run_en = 1'b0, cpol = 1'b0, timer_mode = 1'b0;
  logic [3:0] scale = '0;
  logic [7:0] low = '0, high = '0;
  logic       sclk, lead, trail, tick;

  int errors = 0, checks = 0;
  int cyc = 0, last_cyc = 0, ev_cnt = 0, mon_kind = 0;
  bit armed = 1'b0;
  item_t q[$];
  item_t cur;

  always #2.5 clk = ~clk;

  spi_clk_gen u_spi_clk_gen (
    .clk_i(clk), .rst_ni(rst_ni), .run_en_i(run_en), .cpol_i(cpol),
    .scale_i(scale), .low_i(low), .high_i(high), .timer_mode_i(timer_mode),
    .sclk_o(sclk), .lead_o(lead), .trail_o(trail), .tick_o(tick)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops predicted events and compares kind, gap and level
  always @(negedge clk) begin
    cyc++;
    if (lead || trail || tick) begin
      ev_cnt++;
      mon_kind = lead ? K_LEAD : (trail ? K_TRAIL : K_TICK);
      if (armed && q.size() > 0) begin
        cur = q.pop_front();
        chk({cur.req, " kind"}, mon_kind, cur.kind);
        chk({cur.req, " gap"}, cyc - last_cyc, cur.gap);
        if (mon_kind == K_LEAD)  chk("R5 level after lead", int'(sclk), int'(!cpol));
        if (mon_kind == K_TRAIL) chk("R6 level after trail", int'(sclk), int'(cpol));
      end
      armed    = 1'b1;
      last_cyc = cyc;
    end
  end

  task automatic wait_drain();
    for (int i = 0; i < 20000 && q.size() > 0; i++) @(negedge clk);
    chk("queue drained", q.size(), 0);
  endtask

  task automatic run_spi(bit p, int s, int lo, int hi, int n_ev);
    int u, snap;
    @(negedge clk);
    run_en = 0; timer_mode = 0; cpol = p; scale = 4'(s); low = 8'(lo); high = 8'(hi);
    armed = 0; q.delete();
    u = 1 << s;
    for (int i = 1; i < n_ev; i++) begin
      item_t it;
      if (i % 2 == 1) begin // after a leading edge sclk sits at !p
        it.kind = K_TRAIL; it.gap = (p ? lo : hi) * u; it.req = p ? "R2 low" : "R3 high";
      end else begin
        it.kind = K_LEAD;  it.gap = (p ? hi : lo) * u; it.req = p ? "R3 high" : "R2 low";
      end
      if (s != 0) it.req = {it.req, " R1"};
      q.push_back(it);
    end
    @(negedge clk);
    chk("R5 idle before run", int'(sclk), int'(p));
    run_en = 1;
    wait_drain();
    @(negedge clk); run_en = 0;
    @(negedge clk);
    chk("R7 idle after stop", int'(sclk), int'(p));
    snap = ev_cnt;
    repeat (20) @(negedge clk);
    chk("R7 no strobes after stop", ev_cnt, snap);
  endtask

  task automatic run_timer(int s, int rel, int n_ev);
    @(negedge clk);
    run_en = 0; scale = 4'(s); low = 8'(rel & 8'hff); high = 8'(rel >> 8);
    armed = 0; q.delete();
    for (int i = 1; i < n_ev; i++) begin
      item_t it;
      it.kind = K_TICK; it.gap = (rel + 1) * (1 << s); it.req = "R8 timer period";
      q.push_back(it);
    end
    timer_mode = 1;
    wait_drain();
    @(negedge clk); timer_mode = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int snap;
    repeat (3) @(negedge clk);
    chk("R10 sclk reset", int'(sclk), 0);
    chk("R10 lead reset", int'(lead), 0);
    chk("R10 trail reset", int'(trail), 0);
    chk("R10 tick reset", int'(tick), 0);
    rst_ni = 1;
    repeat (2) @(negedge clk);

    run_spi(0, 0, 3, 5, 7);
    run_spi(1, 2, 2, 1, 6);
    run_spi(0, 1, 1, 1, 8);
    run_spi(1, 0, 7, 2, 5);

    // R4: zero high count, then zero low count
    @(negedge clk); cpol = 1; scale = 0; low = 4; high = 0; run_en = 1;
    snap = ev_cnt;
    repeat (60) @(negedge clk);
    chk("R4 no strobes high=0", ev_cnt, snap);
    chk("R4 idle high=0", int'(sclk), 1);
    low = 0; high = 4;
    repeat (60) @(negedge clk);
    chk("R4 no strobes low=0", ev_cnt, snap);
    chk("R4 idle low=0", int'(sclk), 1);
    run_en = 0;

    run_timer(0, 6, 5);
    run_timer(1, 16'h0102, 3);
    run_timer(3, 0, 4);

    // R9: timer select ignored while run is on (zero low keeps sclk quiet)
    @(negedge clk); scale = 0; low = 0; high = 3; timer_mode = 1; run_en = 1;
    snap = ev_cnt;
    repeat (900) @(negedge clk);
    chk("R9 no tick while running", ev_cnt, snap);
    run_en = 0; timer_mode = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule